// File: doc/BRIEF.md
# Counter-Mode Keystream Combiner

This block turns an external pipelined forward block cipher into a counter-mode stream engine. Each cycle a data word is offered, it forms a 128-bit counter block whose upper half is a per-message nonce and whose lower half is a running count. It hands that block to the cipher and advances the count. The cipher's keystream arrives a fixed number of cycles later. An internal shift line carries the data word for the same number of cycles, so each word meets the keystream made from its own counter block. The two are XORed and registered to give the result.

Encryption and decryption run on the same path. Feeding ciphertext through with the same nonce and start count gives back the plaintext. A load strobe fixes the nonce and the start count for a new message. A sticky flag reports that the count has come back to the start value, which would mean a counter block is about to be reused under the same key.

Top module: `ctr_keystream_unit`

## Requirements
- R1: Every issued counter block carries the nonce in bits [127:64] and the count in bits [63:0]. It appears on `ctr_blk_o` with `ctr_vld_o` high in the same cycle that `din_vld_i` is high and `rst` is low.
- R2: When `load_i` is high, the block issued in that cycle already uses `nonce_i` and `start_i`. The stored nonce and start value are taken from those inputs.
- R3: The count rises by exactly one after each issued block. It stays unchanged in cycles with no valid input.
- R4: The count wraps modulo 2^64 within bits [63:0] and never changes the nonce half.
- R5: `wrap_o` goes high once the count returns to the loaded start value. It stays high until the next load or reset.
- R6: `dout_o` equals the input word XORed with `ks_i`, where `ks_i` is the keystream that belongs to that word's counter block. `dout_o` and `dout_vld_o` appear CIPH_LAT+1 cycles after the word entered, with CIPH_LAT being the cipher's latency.
- R7: Passing the ciphertext of a stream back through the block, with the same nonce and start count, returns the original words exactly.
- R8: Reset clears the output valid, the output word, the delay line, the stored nonce, the count and `wrap_o`. A word in flight when reset is applied is never output.
- R9: When `dout_vld_o` is low, `dout_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Take a new nonce and start count |
| nonce_i | input | 64 | Message nonce to load |
| start_i | input | 64 | First count value to load |
| din_vld_i | input | 1 | Data word valid; issues one counter block |
| din_i | input | 128 | Plaintext or ciphertext word |
| ctr_blk_o | output | 128 | Counter block sent to the cipher |
| ctr_vld_o | output | 1 | Counter block is issued this cycle |
| ks_i | input | 128 | Keystream returned by the cipher |
| dout_vld_o | output | 1 | Result valid |
| dout_o | output | 128 | Result word (zero when not valid) |
| wrap_o | output | 1 | Sticky: count came back to its start value |

## Verification
A random stream with random gaps tests latency alignment. A word that lines up with the wrong keystream slot, or a count that also advances in idle cycles, gives a different XOR result. Loading in the same cycle as the first valid word shows whether the loaded values take effect at once. A start count two below the top of the 64-bit range shows whether the wrap leaks into the nonce. A reduced-width instance is run all the way round its count to check the flag's set point and its stickiness. Reset is applied with words in flight, and an encrypt-then-decrypt round trip separates a real inverse from a path that merely looks plausible.

// File: rtl/ctrx_pkg.sv
package ctrx_pkg;
  localparam int unsigned DEF_NONCE_W = 64;
  localparam int unsigned DEF_COUNT_W = 64;
  localparam int unsigned DEF_CIPH_LAT = 4;
endpackage

// File: rtl/ctrx_counter_gen.sv
module ctrx_counter_gen #(
  parameter int unsigned NONCE_W = ctrx_pkg::DEF_NONCE_W,
  parameter int unsigned COUNT_W = ctrx_pkg::DEF_COUNT_W,
  localparam int unsigned BLK_W = NONCE_W + COUNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [NONCE_W-1:0] nonce_i,
  input  logic [COUNT_W-1:0] start_i,
  input  logic               issue_i,
  output logic [BLK_W-1:0]   blk_o,
  output logic               wrap_o
);
  logic [NONCE_W-1:0] nonce_q, cur_nonce;
  logic [COUNT_W-1:0] cnt_q, start_q, cur_cnt, cur_start, nxt_cnt;
  logic               wrap_q;

  // a load takes effect in its own cycle so no slot is lost
  always_comb begin
    cur_nonce = load_i ? nonce_i : nonce_q;
    cur_cnt   = load_i ? start_i : cnt_q;
    cur_start = load_i ? start_i : start_q;
    nxt_cnt   = issue_i ? cur_cnt + COUNT_W'(1) : cur_cnt;
  end

  assign blk_o  = {cur_nonce, cur_cnt};
  assign wrap_o = wrap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nonce_q <= '0;
      cnt_q   <= '0;
      start_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      nonce_q <= cur_nonce;
      cnt_q   <= nxt_cnt;
      start_q <= cur_start;
      wrap_q  <= (wrap_q & ~load_i) | (issue_i & (nxt_cnt == cur_start));
    end
  end
endmodule

// File: rtl/ctrx_delay_line.sv
module ctrx_delay_line #(
  parameter int unsigned W     = 128,
  parameter int unsigned DEPTH = ctrx_pkg::DEF_CIPH_LAT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);
  logic         vld_q [DEPTH];
  logic [W-1:0] dat_q [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      logic         vld_in;
      logic [W-1:0] dat_in;
      if (g == 0) begin : g_head
        assign vld_in = vld_i;
        assign dat_in = dat_i;
      end else begin : g_body
        assign vld_in = vld_q[g-1];
        assign dat_in = dat_q[g-1];
      end
      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q[g] <= 1'b0;
          dat_q[g] <= '0;
        end else begin
          vld_q[g] <= vld_in;
          dat_q[g] <= dat_in;
        end
      end
    end
  endgenerate

  assign vld_o = vld_q[DEPTH-1];
  assign dat_o = dat_q[DEPTH-1];
endmodule

// File: rtl/ctrx_mix.sv
module ctrx_mix #(
  parameter int unsigned W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  input  logic [W-1:0] ks_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      dat_o <= '0;
    end else begin
      vld_o <= vld_i;
      dat_o <= vld_i ? (dat_i ^ ks_i) : '0;
    end
  end
endmodule

// File: rtl/ctr_keystream_unit.sv
module ctr_keystream_unit #(
  parameter int unsigned NONCE_W  = ctrx_pkg::DEF_NONCE_W,
  parameter int unsigned COUNT_W  = ctrx_pkg::DEF_COUNT_W,
  parameter int unsigned CIPH_LAT = ctrx_pkg::DEF_CIPH_LAT,
  localparam int unsigned BLK_W = NONCE_W + COUNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [NONCE_W-1:0] nonce_i,
  input  logic [COUNT_W-1:0] start_i,
  input  logic               din_vld_i,
  input  logic [BLK_W-1:0]   din_i,
  output logic [BLK_W-1:0]   ctr_blk_o,
  output logic               ctr_vld_o,
  input  logic [BLK_W-1:0]   ks_i,
  output logic               dout_vld_o,
  output logic [BLK_W-1:0]   dout_o,
  output logic               wrap_o
);
  logic             issue;
  logic             tap_vld;
  logic [BLK_W-1:0] tap_dat;

  assign issue     = din_vld_i & ~rst;
  assign ctr_vld_o = issue;

  ctrx_counter_gen #(.NONCE_W(NONCE_W), .COUNT_W(COUNT_W)) u_gen (
    .clk(clk), .rst(rst), .load_i(load_i), .nonce_i(nonce_i),
    .start_i(start_i), .issue_i(issue), .blk_o(ctr_blk_o), .wrap_o(wrap_o)
  );

  ctrx_delay_line #(.W(BLK_W), .DEPTH(CIPH_LAT)) u_dly (
    .clk(clk), .rst(rst), .vld_i(issue), .dat_i(din_i),
    .vld_o(tap_vld), .dat_o(tap_dat)
  );

  ctrx_mix #(.W(BLK_W)) u_mix (
    .clk(clk), .rst(rst), .vld_i(tap_vld), .dat_i(tap_dat), .ks_i(ks_i),
    .vld_o(dout_vld_o), .dat_o(dout_o)
  );
endmodule

// File: rtl/ctr_keystream_unit_chk.sv
module ctr_keystream_unit_chk #(
  parameter int unsigned NONCE_W = 64,
  parameter int unsigned COUNT_W = 64,
  localparam int unsigned BLK_W = NONCE_W + COUNT_W
) (
  input logic             clk,
  input logic             rst,
  input logic             load_i,
  input logic [BLK_W-1:0] ctr_blk_o,
  input logic             ctr_vld_o,
  input logic             tap_vld,
  input logic             dout_vld_o,
  input logic [BLK_W-1:0] dout_o,
  input logic             wrap_o
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (ctr_vld_o && !load_i) |=> (load_i || ctr_blk_o[COUNT_W-1:0] == COUNT_W'($past(ctr_blk_o[COUNT_W-1:0]) + 1'b1))); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ctr_vld_o && !load_i) |=> (load_i || $stable(ctr_blk_o[COUNT_W-1:0]))); // R3
  AST_NONCE_KEEP: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> (load_i || $stable(ctr_blk_o[BLK_W-1:COUNT_W]))); // R4
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wrap_o && !load_i) |=> wrap_o); // R5
  AST_OUT_ALIGN: assert property (@(posedge clk) disable iff (rst)
    tap_vld |=> dout_vld_o); // R6
  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tap_vld |=> !dout_vld_o); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !dout_vld_o |-> (dout_o == '0)); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!dout_vld_o && !wrap_o)); // R8
endmodule

bind ctr_keystream_unit ctr_keystream_unit_chk #(.NONCE_W(NONCE_W), .COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rst(rst), .load_i(load_i), .ctr_blk_o(ctr_blk_o),
  .ctr_vld_o(ctr_vld_o), .tap_vld(tap_vld), .dout_vld_o(dout_vld_o),
  .dout_o(dout_o), .wrap_o(wrap_o)
);

// File: tb/sim_ctr_keystream_unit.sv
module sim_ctr_keystream_unit;
  localparam int L = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_i = 1'b0;
  logic [63:0]  nonce_i = '0;
  logic [63:0]  start_i = '0;
  logic         din_vld_i = 1'b0;
  logic [127:0] din_i = '0;
  logic [127:0] ctr_blk_o, ks_i, dout_o;
  logic         ctr_vld_o, dout_vld_o, wrap_o;

  always #5 clk = ~clk;

  ctr_keystream_unit #(.NONCE_W(64), .COUNT_W(64), .CIPH_LAT(L)) u0 (
    .clk(clk), .rst(rst), .load_i(load_i), .nonce_i(nonce_i), .start_i(start_i),
    .din_vld_i(din_vld_i), .din_i(din_i), .ctr_blk_o(ctr_blk_o), .ctr_vld_o(ctr_vld_o),
    .ks_i(ks_i), .dout_vld_o(dout_vld_o), .dout_o(dout_o), .wrap_o(wrap_o)
  );

  // reduced-width instance for reaching the count wrap
  logic        s_load = 1'b0, s_vld = 1'b0;
  logic [7:0]  s_nonce = '0, s_start = '0;
  logic [15:0] s_blk, s_dout;
  logic        s_cvld, s_dvld, s_wrap;
  ctr_keystream_unit #(.NONCE_W(8), .COUNT_W(8), .CIPH_LAT(2)) u1 (
    .clk(clk), .rst(rst), .load_i(s_load), .nonce_i(s_nonce), .start_i(s_start),
    .din_vld_i(s_vld), .din_i(16'h0), .ctr_blk_o(s_blk), .ctr_vld_o(s_cvld),
    .ks_i(16'h0), .dout_vld_o(s_dvld), .dout_o(s_dout), .wrap_o(s_wrap)
  );

  function automatic logic [127:0] ks_fn(input logic [127:0] b);
    return {b[63:0], b[127:64]} ^ {b[120:0], 7'b0} ^ 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;
  endfunction

  // fixed-latency cipher stand-in
  logic [127:0] stub_q [L];
  always @(posedge clk) begin
    stub_q[0] <= ks_fn(ctr_blk_o);
    for (int i = 1; i < L; i++) stub_q[i] <= stub_q[i-1];
  end
  assign ks_i = stub_q[L-1];

  int nchk = 0, nerr = 0, cycle = 0;
  logic [127:0] q_dat [$];
  int           q_due [$];
  logic [63:0]  m_nonce = '0, m_cnt = '0, m_start = '0;
  bit           m_wrap = 1'b0;
  int           cap_mode = 0, n_ct = 0, n_pt = 0, n_orig = 0;
  logic [127:0] ct [64];
  logic [127:0] pt [64];
  logic [127:0] orig [64];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_out();
    if (q_due.size() > 0 && q_due[0] == cycle) begin
      chk(dout_vld_o === 1'b1, "R6 output valid timing", 128'(dout_vld_o), 128'd1);
      chk(dout_o === q_dat[0], "R6 XOR result", dout_o, q_dat[0]);
      if (cap_mode == 1 && n_ct < 64) begin ct[n_ct] = dout_o; n_ct++; end
      if (cap_mode == 2 && n_pt < 64) begin pt[n_pt] = dout_o; n_pt++; end
      void'(q_dat.pop_front());
      void'(q_due.pop_front());
    end else begin
      chk(dout_vld_o === 1'b0, "R6 no spurious valid", 128'(dout_vld_o), 128'd0);
      chk(dout_o === '0, "R9 idle output zero", dout_o, 128'd0);
    end
    chk(wrap_o === m_wrap, "R5 wrap flag", 128'(wrap_o), 128'(m_wrap));
  endtask

  task automatic cyc(input bit r, input bit ld, input bit v, input logic [127:0] d,
                     input logic [63:0] n, input logic [63:0] s);
    logic [127:0] exp_blk;
    @(negedge clk);
    cycle++;
    check_out();
    rst = r; load_i = ld; nonce_i = n; start_i = s; din_vld_i = v; din_i = d;
    if (r) begin
      q_dat.delete(); q_due.delete();
      m_nonce = '0; m_cnt = '0; m_start = '0; m_wrap = 1'b0;
      exp_blk = '0;
    end else begin
      if (ld) begin m_nonce = n; m_cnt = s; m_start = s; m_wrap = 1'b0; end
      exp_blk = {m_nonce, m_cnt};
      if (v) begin
        q_dat.push_back(d ^ ks_fn(exp_blk));
        q_due.push_back(cycle + L + 1);
        m_cnt = m_cnt + 64'd1;
        if (m_cnt == m_start) m_wrap = 1'b1;
      end
    end
    #1;
    chk(ctr_vld_o === (v && !r), "R1 issue strobe", 128'(ctr_vld_o), 128'(v && !r));
    if (!r && v) chk(ctr_blk_o === exp_blk, ld ? "R2 load-cycle block" : "R1 R3 R4 counter block", ctr_blk_o, exp_blk);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) cyc(1'b0, 1'b0, 1'b0, '0, '0, '0);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [127:0] w;
    logic [63:0]  nn, ss;
    void'($urandom(32'h1234_5678));
    // R8: reset state
    cyc(1'b1, 1'b0, 1'b0, '0, '0, '0);
    cyc(1'b1, 1'b0, 1'b0, '0, '0, '0);
    @(negedge clk); #1;
    chk(dout_vld_o === 1'b0 && dout_o === '0 && wrap_o === 1'b0 && ctr_blk_o === '0,
        "R8 reset state", {dout_o[126:0], dout_vld_o}, 128'd0);
    cycle++;
    cyc(1'b0, 1'b0, 1'b0, '0, '0, '0);

    // R7: encrypt random stream with gaps; load in same cycle as first word (R2)
    nn = {$urandom(), $urandom()}; ss = {$urandom(), $urandom()};
    cap_mode = 1;
    w = rnd128(); orig[n_orig] = w; n_orig++;
    cyc(1'b0, 1'b1, 1'b1, w, nn, ss);
    for (int i = 0; i < 40; i++) begin
      if (($urandom() % 10) < 7 && n_orig < 64) begin
        w = rnd128(); orig[n_orig] = w; n_orig++;
        cyc(1'b0, 1'b0, 1'b1, w, '0, '0);
      end else cyc(1'b0, 1'b0, 1'b0, rnd128(), '0, '0);
    end
    idle(L + 3);
    chk(n_ct == n_orig, "R6 every word emerged", 128'(n_ct), 128'(n_orig));
    // decrypt back-to-back, load in an idle cycle first
    cap_mode = 2;
    cyc(1'b0, 1'b1, 1'b0, '0, nn, ss);
    for (int i = 0; i < n_ct; i++) cyc(1'b0, 1'b0, 1'b1, ct[i], '0, '0);
    idle(L + 3);
    cap_mode = 0;
    chk(n_pt == n_orig, "R7 count after round trip", 128'(n_pt), 128'(n_orig));
    for (int i = 0; i < n_pt; i++)
      chk(pt[i] === orig[i], "R7 round trip word", pt[i], orig[i]);
    chk(ct[0] !== orig[0], "R6 ciphertext differs", ct[0], ~orig[0]);

    // R4: 64-bit count wrap keeps nonce
    nn = 64'hA5A5_0000_FFFF_1234;
    cyc(1'b0, 1'b1, 1'b1, rnd128(), nn, 64'hFFFF_FFFF_FFFF_FFFE);
    cyc(1'b0, 1'b0, 1'b1, rnd128(), '0, '0);
    cyc(1'b0, 1'b0, 1'b1, rnd128(), '0, '0);
    chk(ctr_blk_o === {nn, 64'd0}, "R4 wrapped block", ctr_blk_o, {nn, 64'd0});

    // R3: gaps hold the count; all-ones and all-zeros data
    idle(3);
    cyc(1'b0, 1'b0, 1'b1, '1, '0, '0);
    idle(2);
    cyc(1'b0, 1'b0, 1'b1, '0, '0, '0);
    idle(L + 2);

    // R8: reset with words in flight
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b1, rnd128(), '0, '0);
    cyc(1'b1, 1'b0, 1'b1, rnd128(), '0, '0);
    cyc(1'b1, 1'b0, 1'b0, '0, '0, '0);
    idle(L + 3);
    chk(ctr_blk_o === '0, "R8 counter cleared", ctr_blk_o, 128'd0);

    // R5 R4: narrow instance runs a full lap of its 8-bit count
    @(negedge clk);
    s_load = 1'b1; s_vld = 1'b1; s_nonce = 8'h5A; s_start = 8'hFE;
    for (int k = 1; k <= 256; k++) begin
      @(negedge clk);
      s_load = 1'b0; s_vld = (k < 256);
      #1;
      chk(s_blk === {8'h5A, 8'(8'hFE + k)}, "R4 narrow count and nonce", 128'(s_blk), 128'({8'h5A, 8'(8'hFE + k)}));
      chk(s_wrap === (k == 256), "R5 wrap set point", 128'(s_wrap), 128'(k == 256));
    end
    repeat (3) @(negedge clk);
    chk(s_wrap === 1'b1, "R5 wrap sticky", 128'(s_wrap), 128'd1);
    s_load = 1'b1;
    @(negedge clk);
    s_load = 1'b0;
    #1;
    chk(s_wrap === 1'b0, "R5 wrap cleared by load", 128'(s_wrap), 128'd0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule